// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block drives the latch-enable, write-strobe and data pins of a small-page NAND flash device for one command transaction. A host presents a command code, an optional column, an optional page address, the device page size (256 or 512 bytes) and a flag for high-density parts, then pulses `start`. The block first plays out the command byte or bytes with the command latch high. It then plays out the address bytes with the address latch high, lets both latches fall, and waits a settle interval before it pulses `done`.

When the command is the sequential data-input code (0x80), the block first positions the device's internal pointer. It chooses a pointer command from the page size and the column, and it rebases the column to that area. The caller holds chip enable. Data-phase transfers and error correction belong to other blocks.

Command codes used by the block: reset 0xFF, first-half pointer 0x00, second-half pointer 0x01, spare-area pointer 0x50, data input 0x80.

Top module: `nand_cmd_seq`

## Requirements
- R1: `cle` and `ale` are never high together. All command bytes are strobed while `cle` is high. All address bytes follow them while `ale` is high. `cle` is high for exactly 2·WE_CYC cycles per command byte, and `ale` for exactly 2·WE_CYC cycles per address byte.
- R2: For any command code other than 0x80, exactly one command byte is sent, equal to `cmd_code`, and a supplied column goes out as its low 8 bits unchanged.
- R3: For code 0x80 with `page_512`=0 and a supplied column of 256 or more, the command bytes are 0xFF, 0x50, 0x80 in that order, and the column byte is the low 8 bits of column−256.
- R4: For code 0x80 with `page_512`=1 and a supplied column from 256 to 511, the command bytes are 0x01, 0x80, and the column byte is column−256.
- R5: For code 0x80 with `page_512`=1 and a supplied column of 512 or more, the command bytes are 0x50, 0x80, and the column byte is the low 8 bits of column−512.
- R6: For code 0x80 in every other case, including no column, the command bytes are 0x00, 0x80, and any column is sent unchanged.
- R7: The address bytes are the column byte when `col_valid` is set, followed by `page[7:0]` and then `page[15:8]` when `page_valid` is set.
- R8: A third page byte `{4'h0, page[19:16]}` follows only when both `page_valid` and `big_dev` are set.
- R9: Each byte produces one `we_n` low pulse of exactly WE_CYC cycles, followed by WE_CYC high cycles in the same latch phase. `dq_oe` is high only while `we_n` is low.
- R10: After the last latch cycle, both latches stay low for exactly ceil(SETTLE_NS·CLK_MHZ/1000) cycles (at least one). Then `done` is high for exactly one cycle.
- R11: `busy` rises in the cycle after an accepted `start` and falls after the `done` cycle. The request inputs are sampled only at that `start`. A `start` while busy is ignored, and a new `start` is accepted once idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction when idle |
| cmd_code | input | 8 | Command code |
| col_valid | input | 1 | A column address is supplied |
| col | input | 10 | Column address |
| page_valid | input | 1 | A page address is supplied |
| page | input | 20 | Page address |
| page_512 | input | 1 | 1: 512-byte pages, 0: 256-byte pages |
| big_dev | input | 1 | Device needs a third page-address byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Active-low write strobe |
| dq_oe | output | 1 | Data bus drive enable |
| dq_out | output | 8 | Data bus value |

## Verification
The pointer-selection logic is tried with columns placed on each side of 256 and 512, for both page sizes. This separates the reset-plus-spare prefix, the second-half prefix, the spare prefix and the plain first-half prefix, and it shows any off-by-one in the rebased column byte. Requests with no column, no page, page-only and high-density pages show whether the address list is assembled and counted correctly. Non-load codes carrying large columns confirm that rebasing stays confined to the data-input code. A random mix adds arbitrary codes and addresses, and some transactions receive a second `start` and scrambled inputs mid-flight, which shows whether the request is held from the accepted `start`.

// File: rtl/nseq_pkg.sv
`timescale 1ns/1ps
package nseq_pkg;
  localparam int COL_W      = 10;
  localparam int PAGE_W     = 20;
  localparam int CMD_SLOTS  = 3;
  localparam int ADDR_SLOTS = 4;

  localparam logic [7:0] OP_RESET     = 8'hFF;
  localparam logic [7:0] OP_PTR_A     = 8'h00;
  localparam logic [7:0] OP_PTR_B     = 8'h01;
  localparam logic [7:0] OP_PTR_SPARE = 8'h50;
  localparam logic [7:0] OP_LOAD      = 8'h80;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_SETTLE, ST_DONE
  } nseq_state_e;

  typedef struct packed {
    logic [7:0]        code;
    logic              col_v;
    logic [COL_W-1:0]  col;
    logic              page_v;
    logic [PAGE_W-1:0] page;
    logic              wide;
    logic              big;
  } nseq_req_t;

  // number of bytes in the command phase
  function automatic logic [1:0] cmd_count(nseq_req_t r);
    if (r.code != OP_LOAD) return 2'd1;
    if (!r.wide && r.col_v && (int'(r.col) >= 256)) return 2'd3;
    return 2'd2;
  endfunction

  // pointer command placed just before the data-input code
  function automatic logic [7:0] lead_ptr(nseq_req_t r);
    if (r.col_v && r.wide && (int'(r.col) >= 512)) return OP_PTR_SPARE;
    if (r.col_v && (int'(r.col) >= 256)) return r.wide ? OP_PTR_B : OP_PTR_SPARE;
    return OP_PTR_A;
  endfunction

  // column byte after rebasing into the selected area
  function automatic logic [7:0] col_byte(nseq_req_t r);
    logic [COL_W-1:0] v;
    v = r.col;
    if (r.code == OP_LOAD && r.col_v) begin
      if (r.wide && (int'(r.col) >= 512)) v = r.col - COL_W'(512);
      else if (int'(r.col) >= 256)        v = r.col - COL_W'(256);
    end
    return v[7:0];
  endfunction
endpackage

// File: rtl/nseq_plan.sv
`timescale 1ns/1ps
module nseq_plan
  import nseq_pkg::*;
(
  input  nseq_req_t                         req,
  output logic [CMD_SLOTS-1:0][7:0]         cmd_byte,
  output logic [1:0]                        n_cmd,
  output logic [ADDR_SLOTS-1:0][7:0]        addr_byte,
  output logic [2:0]                        n_addr
);
  logic [7:0] cbyte;

  always_comb begin
    cbyte    = col_byte(req);
    n_cmd    = cmd_count(req);
    cmd_byte = '0;
    case (n_cmd)
      2'd3: begin
        cmd_byte[0] = OP_RESET;
        cmd_byte[1] = OP_PTR_SPARE;
        cmd_byte[2] = OP_LOAD;
      end
      2'd2: begin
        cmd_byte[0] = lead_ptr(req);
        cmd_byte[1] = OP_LOAD;
      end
      default: cmd_byte[0] = req.code;
    endcase
  end

  always_comb begin
    addr_byte = '0;
    n_addr    = 3'd0;
    if (req.col_v) begin
      addr_byte[0] = cbyte;
      n_addr       = 3'd1;
    end
    if (req.page_v) begin
      addr_byte[n_addr[1:0]]        = req.page[7:0];
      addr_byte[n_addr[1:0] + 2'd1] = req.page[15:8];
      n_addr = n_addr + 3'd2;
      if (req.big) begin
        addr_byte[n_addr[1:0]] = {4'h0, req.page[19:16]};
        n_addr = n_addr + 3'd1;
      end
    end
  end
endmodule

// File: rtl/nseq_strobe.sv
`timescale 1ns/1ps
module nseq_strobe #(
  parameter int WE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic we_n,
  output logic drive,
  output logic slot_end
);
  localparam int SLOT = 2 * WE_CYC;
  localparam int TW   = (SLOT > 2) ? $clog2(SLOT) : 1;

  logic [TW-1:0] tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tick <= '0;
    else if (!run)     tick <= '0;
    else if (slot_end) tick <= '0;
    else               tick <= tick + TW'(1);
  end

  assign drive    = run && (tick < TW'(WE_CYC));
  assign we_n     = !drive;
  assign slot_end = run && (tick == TW'(SLOT - 1));
endmodule

// File: rtl/nseq_settle.sv
`timescale 1ns/1ps
module nseq_settle #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (!en) cnt <= '0;
    else          cnt <= cnt + CW'(1);
  end

  assign expire = en && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/nand_cmd_seq.sv
`timescale 1ns/1ps
module nand_cmd_seq
  import nseq_pkg::*;
#(
  parameter int WE_CYC    = 2,
  parameter int CLK_MHZ   = 250,
  parameter int SETTLE_NS = 15000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        cmd_code,
  input  logic              col_valid,
  input  logic [COL_W-1:0]  col,
  input  logic              page_valid,
  input  logic [PAGE_W-1:0] page,
  input  logic              page_512,
  input  logic              big_dev,
  output logic              busy,
  output logic              done,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic              dq_oe,
  output logic [7:0]        dq_out
);
  localparam int SETTLE_RAW = (SETTLE_NS * CLK_MHZ + 999) / 1000;
  localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;

  nseq_state_e state;
  nseq_req_t   req_q;
  logic [1:0]  idx;

  logic [CMD_SLOTS-1:0][7:0]  cmd_byte;
  logic [ADDR_SLOTS-1:0][7:0] addr_byte;
  logic [1:0] n_cmd;
  logic [2:0] n_addr;

  // named internal events
  logic slot_end;
  logic settle_end;
  logic strobe_run;
  logic last_cmd;
  logic last_addr;

  nseq_plan u_plan (
    .req       (req_q),
    .cmd_byte  (cmd_byte),
    .n_cmd     (n_cmd),
    .addr_byte (addr_byte),
    .n_addr    (n_addr)
  );

  assign strobe_run = (state == ST_CMD) || (state == ST_ADDR);

  nseq_strobe #(.WE_CYC(WE_CYC)) u_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (strobe_run),
    .we_n     (we_n),
    .drive    (dq_oe),
    .slot_end (slot_end)
  );

  nseq_settle #(.LIMIT(SETTLE_CYC)) u_settle (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (state == ST_SETTLE),
    .expire (settle_end)
  );

  assign last_cmd  = (idx == n_cmd - 2'd1);
  assign last_addr = ({1'b0, idx} == n_addr - 3'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
      req_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          req_q <= '{code: cmd_code, col_v: col_valid, col: col,
                     page_v: page_valid, page: page,
                     wide: page_512, big: big_dev};
          idx   <= '0;
          state <= ST_CMD;
        end
        ST_CMD: if (slot_end) begin
          if (last_cmd) begin
            idx   <= '0;
            state <= (n_addr != 3'd0) ? ST_ADDR : ST_SETTLE;
          end else begin
            idx <= idx + 2'd1;
          end
        end
        ST_ADDR: if (slot_end) begin
          if (last_addr) begin
            idx   <= '0;
            state <= ST_SETTLE;
          end else begin
            idx <= idx + 2'd1;
          end
        end
        ST_SETTLE: if (settle_end) state <= ST_DONE;
        ST_DONE:   state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    dq_out = 8'h00;
    if (state == ST_CMD)       dq_out = cmd_byte[idx];
    else if (state == ST_ADDR) dq_out = addr_byte[idx];
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);
  assign cle  = (state == ST_CMD);
  assign ale  = (state == ST_ADDR);
endmodule

// File: rtl/nseq_chk.sv
`timescale 1ns/1ps
module nseq_chk #(
  parameter int WE_CYC     = 2,
  parameter int SETTLE_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic cle,
  input logic ale,
  input logic we_n,
  input logic dq_oe,
  input logic slot_end,
  input logic settle_end
);
  int low_cnt;
  int quiet_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt   <= 0;
      quiet_cnt <= 0;
    end else begin
      low_cnt <= we_n ? 0 : low_cnt + 1;
      if (!busy)                     quiet_cnt <= 0;
      else if (!cle && !ale && !done) quiet_cnt <= quiet_cnt + 1;
    end
  end

  // R1
  cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  // R1
  ale_after_cle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |-> $past(cle));
  // R9
  oe_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !we_n);
  // R9
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (low_cnt == WE_CYC));
  // R9
  strobe_in_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (cle || ale));
  // R9
  slot_tail_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |-> we_n);
  // R10
  settle_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settle_end |=> done);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  settle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (quiet_cnt == SETTLE_CYC && !cle && !ale));
  // R11
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R11
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

bind nand_cmd_seq nseq_chk #(.WE_CYC(WE_CYC), .SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .cle        (cle),
  .ale        (ale),
  .we_n       (we_n),
  .dq_oe      (dq_oe),
  .slot_end   (slot_end),
  .settle_end (settle_end)
);

// File: tb/sim_nand_cmd_seq.sv
`timescale 1ns/1ps
module sim_nand_cmd_seq;
  localparam int WE_CYC     = 2;
  localparam int CLK_MHZ    = 250;
  localparam int SETTLE_NS  = 100;
  localparam int SETTLE_EXP = (SETTLE_NS * CLK_MHZ + 999) / 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  cmd_code = 8'h00;
  logic        col_valid = 1'b0;
  logic [9:0]  col = 10'd0;
  logic        page_valid = 1'b0;
  logic [19:0] page = 20'd0;
  logic        page_512 = 1'b0;
  logic        big_dev = 1'b0;
  wire         busy, done, cle, ale, we_n, dq_oe;
  wire  [7:0]  dq_out;

  nand_cmd_seq #(.WE_CYC(WE_CYC), .CLK_MHZ(CLK_MHZ), .SETTLE_NS(SETTLE_NS)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_code(cmd_code),
    .col_valid(col_valid), .col(col), .page_valid(page_valid), .page(page),
    .page_512(page_512), .big_dev(big_dev), .busy(busy), .done(done),
    .cle(cle), .ale(ale), .we_n(we_n), .dq_oe(dq_oe), .dq_out(dq_out)
  );

  always #2 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- port monitor ----------------
  logic [7:0] cap_b [8];
  logic [1:0] cap_k [8];   // 01 = command phase, 10 = address phase
  int cap_n = 0, low_run = 0, bad_width = 0, bad_oe = 0;
  int cle_cyc = 0, ale_cyc = 0, both_hi = 0, quiet = 0, done_cnt = 0;
  logic [7:0] lb = 8'h00;
  logic [1:0] lk = 2'b00;
  logic prev_busy = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !prev_busy) begin
        cap_n = 0; bad_width = 0; bad_oe = 0; cle_cyc = 0; ale_cyc = 0;
        both_hi = 0; quiet = 0; done_cnt = 0; low_run = 0;
      end
      prev_busy = busy;
      if (cle) cle_cyc++;
      if (ale) ale_cyc++;
      if (cle && ale) both_hi++;
      if (busy && !cle && !ale && !done) quiet++;
      if (done) done_cnt++;
      if (dq_oe && we_n) bad_oe++;
      if (!we_n) begin
        low_run++;
        lb = dq_out;
        lk = {ale, cle};
      end else if (low_run != 0) begin
        if (low_run != WE_CYC) bad_width++;
        if (cap_n < 8) begin
          cap_b[cap_n] = lb;
          cap_k[cap_n] = lk;
        end
        cap_n++;
        low_run = 0;
      end
    end
  end

  // ---------------- expected model ----------------
  logic [7:0] exp_b [8];
  logic [1:0] exp_k [8];
  int exp_n = 0, exp_ncmd = 0, exp_naddr = 0;

  task automatic push_exp(input logic [7:0] b, input logic [1:0] k);
    exp_b[exp_n] = b;
    exp_k[exp_n] = k;
    exp_n++;
  endtask

  task automatic build_exp(input logic [7:0] c, input logic cv, input logic [9:0] cl,
                           input logic pv, input logic [19:0] pg,
                           input logic w, input logic bg);
    int v;
    exp_n = 0;
    v = cl;
    if (c == 8'h80) begin
      if (!w && cv && cl >= 10'd256) begin
        push_exp(8'hFF, 2'b01); push_exp(8'h50, 2'b01); v = cl - 256;
      end else if (w && cv && cl >= 10'd512) begin
        push_exp(8'h50, 2'b01); v = cl - 512;
      end else if (w && cv && cl >= 10'd256) begin
        push_exp(8'h01, 2'b01); v = cl - 256;
      end else begin
        push_exp(8'h00, 2'b01);
      end
      push_exp(8'h80, 2'b01);
    end else begin
      push_exp(c, 2'b01);
    end
    exp_ncmd = exp_n;
    if (cv) push_exp(8'(v % 256), 2'b10);
    if (pv) begin
      push_exp(pg[7:0], 2'b10);
      push_exp(pg[15:8], 2'b10);
      if (bg) push_exp({4'h0, pg[19:16]}, 2'b10);
    end
    exp_naddr = exp_n - exp_ncmd;
  endtask

  function automatic string tag_of(input logic [7:0] c, input logic cv, input logic [9:0] cl,
                                   input logic pv, input logic w, input logic bg);
    string t;
    if (c != 8'h80)                    t = "R2";
    else if (!w && cv && cl >= 10'd256) t = "R3";
    else if (w && cv && cl >= 10'd512)  t = "R5";
    else if (w && cv && cl >= 10'd256)  t = "R4";
    else                               t = "R6";
    t = {t, "+R7"};
    if (pv && bg) t = {t, "+R8"};
    return t;
  endfunction

  // ---------------- one transaction ----------------
  task automatic run_txn(input logic [7:0] c, input logic cv, input logic [9:0] cl,
                         input logic pv, input logic [19:0] pg,
                         input logic w, input logic bg, input bit poke);
    string t;
    int waitc;
    int bad_at;
    build_exp(c, cv, cl, pv, pg, w, bg);
    t = tag_of(c, cv, cl, pv, w, bg);
    @(negedge clk);
    cmd_code = c; col_valid = cv; col = cl; page_valid = pv; page = pg;
    page_512 = w; big_dev = bg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R11", "busy after start", int'(busy), 1);
    // R11: inputs change after the accepted start
    cmd_code = 8'($urandom); col = 10'($urandom); page = 20'($urandom);
    col_valid = 1'($urandom); page_valid = 1'($urandom);
    page_512 = 1'($urandom); big_dev = 1'($urandom);
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waitc = 0;
    while (!done && waitc < 5000) begin
      @(negedge clk);
      waitc++;
    end
    if (!done) check(1'b0, "R10", "done timeout", 0, 1);
    repeat (4) @(negedge clk);
    check(busy === 1'b0, "R11", "idle after done", int'(busy), 0);
    check(done_cnt == 1, "R10", "done pulse count", done_cnt, 1);
    check(cap_n == exp_n, t, "byte count", cap_n, exp_n);
    bad_at = -1;
    for (int i = 0; i < exp_n && i < cap_n && i < 8; i++)
      if (bad_at < 0 && (cap_b[i] !== exp_b[i] || cap_k[i] !== exp_k[i])) bad_at = i;
    if (bad_at >= 0)
      check(1'b0, t, $sformatf("byte %0d value/phase", bad_at),
            int'({cap_k[bad_at], cap_b[bad_at]}), int'({exp_k[bad_at], exp_b[bad_at]}));
    else
      check(1'b1, t, "byte sequence", 0, 0);
    check(cle_cyc == exp_ncmd * 2 * WE_CYC, "R1", "cle cycles", cle_cyc, exp_ncmd * 2 * WE_CYC);
    check(ale_cyc == exp_naddr * 2 * WE_CYC, "R1", "ale cycles", ale_cyc, exp_naddr * 2 * WE_CYC);
    check(both_hi == 0, "R1", "cle and ale together", both_hi, 0);
    check(bad_width == 0, "R9", "we_n low width errors", bad_width, 0);
    check(bad_oe == 0, "R9", "bus driven outside pulse", bad_oe, 0);
    check(quiet == SETTLE_EXP, "R10", "settle cycles", quiet, SETTLE_EXP);
  endtask

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL R10 watchdog expired: got %0d expected %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] codes [8];
    void'($urandom(32'd4242));
    codes[0] = 8'h80; codes[1] = 8'h80; codes[2] = 8'h00; codes[3] = 8'h01;
    codes[4] = 8'h50; codes[5] = 8'h60; codes[6] = 8'h70; codes[7] = 8'h90;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0, "R11", "reset busy", int'(busy), 0);
    check(done === 1'b0, "R10", "reset done", int'(done), 0);
    check(cle === 1'b0 && ale === 1'b0, "R1", "reset latches", int'({cle, ale}), 0);
    check(we_n === 1'b1 && dq_oe === 1'b0, "R9", "reset strobe", int'({we_n, dq_oe}), 2);

    // directed: plain commands
    run_txn(8'h00, 1, 10'd5,   1, 20'h12345, 0, 0, 0);   // R2 R7
    run_txn(8'h00, 1, 10'd300, 1, 20'hABCDE, 1, 1, 0);   // R2: no rebasing, R8
    run_txn(8'h70, 0, 10'd0,   0, 20'h0,     1, 0, 0);   // R2, no address
    run_txn(8'h60, 0, 10'd0,   1, 20'hF5A3C, 0, 1, 0);   // R8 page only
    run_txn(8'h60, 0, 10'd0,   1, 20'hF5A3C, 0, 0, 0);   // R8 absent
    // directed: data-input pointer selection
    run_txn(8'h80, 1, 10'd300, 1, 20'h00102, 0, 0, 0);   // R3
    run_txn(8'h80, 1, 10'd256, 1, 20'h00102, 0, 0, 0);   // R3 boundary
    run_txn(8'h80, 1, 10'd255, 1, 20'h00102, 0, 0, 0);   // R6 boundary
    run_txn(8'h80, 1, 10'd300, 1, 20'h3_4567, 1, 0, 0);  // R4
    run_txn(8'h80, 1, 10'd256, 1, 20'h3_4567, 1, 0, 0);  // R4 boundary
    run_txn(8'h80, 1, 10'd511, 1, 20'h9_8765, 1, 1, 0);  // R4 top, R8
    run_txn(8'h80, 1, 10'd512, 1, 20'h0_0001, 1, 0, 0);  // R5 boundary
    run_txn(8'h80, 1, 10'd515, 1, 20'h0_0001, 1, 0, 0);  // R5
    run_txn(8'h80, 1, 10'd10,  1, 20'h0_0001, 1, 0, 0);  // R6
    run_txn(8'h80, 0, 10'd700, 1, 20'h0_7777, 0, 1, 0);  // R6 no column
    // R11: start while busy
    run_txn(8'h80, 1, 10'd260, 1, 20'h5_1234, 0, 1, 1);
    run_txn(8'h70, 0, 10'd0,   0, 20'h0,      0, 0, 1);

    // constrained random
    for (int k = 0; k < 60; k++) begin
      logic [7:0] c;
      logic [9:0] cl;
      c  = ($urandom_range(0, 3) == 0) ? 8'($urandom) : codes[$urandom_range(0, 7)];
      cl = ($urandom_range(0, 3) == 0) ? 10'($urandom) : 10'($urandom_range(0, 527));
      run_txn(c, 1'($urandom), cl, 1'($urandom), 20'($urandom),
              1'($urandom), 1'($urandom), bit'($urandom_range(0, 2) == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule